// File: doc/BRIEF.md
# Receive Lane Synchronization Controller

This block brings up the receive side of one serial converter lane. Each link clock it takes four already decoded octets, each octet with a control-character flag and a decode/disparity error flag. Out of reset it holds its synchronization request low and looks for a run of comma characters. It releases the request after enough commas in a row, and confirms code group lock once a further run of clean characters follows. When lock is lost through repeated decode errors, it raises the request again.

Once code group lock holds, the block tracks frame alignment. The first octet that is not a comma, in any of the four byte lanes of the bus, marks the start of framing. If that octet opens an initial alignment sequence, the block follows its four multiframes. It checks that each multiframe closes with the alignment marker, and copies the fourteen link configuration octets of the second multiframe into four 32-bit registers that the link layer reads back.

Top module: `rx_link_sync`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sync_n`, `cgs_done`, `fs_locked`, `ilas_done`, `cfg_valid` and `ila_err` are 0 and all four configuration registers are zero.
- R2: `sync_n` goes high once COMMA_RUN (default 4) consecutive error-free comma octets (control flag set, value 8'hBC) have been received. Octet 0 (bits 7:0) is the earliest in time and octet 3 the latest. Any other octet restarts the count, and a count may span two bus words.
- R3: `cgs_done` rises only after CHECK_RUN (default 4) further octets with no error flag follow the comma run. Whenever `cgs_done` is high, `sync_n` is high.
- R4: An octet with its error flag set while the further clean octets are being counted sends `sync_n` low again, and the comma count restarts from zero at the next octet.
- R5: With `cgs_done` high, `fs_locked` stays low while only commas arrive. It goes high on the first non-comma octet, whichever of the four byte positions holds it.
- R6: If that first non-comma octet is K28.0 (control, 8'h1C), the alignment sequence is followed; otherwise no configuration is captured. In the second multiframe, multiframe positions 2 to 15 hold configuration octets 0 to 13. Octet j is stored in register j/4 at bits 8*(j%4)+7 down to 8*(j%4), and the upper 16 bits of register 3 stay zero. `cfg_valid` rises at the end of that multiframe if position 1 held K28.4 (control, 8'h9C). The registers do not change while `fs_locked` is low.
- R7: In code group lock, ERR_LIMIT (default 3) octets with the error flag within one window of MF_OCTETS/4 link clocks drop the block back to comma search. `sync_n`, `cgs_done`, `fs_locked`, `ilas_done` and `cfg_valid` all go low. Fewer errors per window are tolerated.
- R8: `ila_err` pulses high for one cycle for each alignment multiframe whose last octet (position MF_OCTETS-1) is not K28.3 (control, 8'h7C).
- R9: `ilas_done` goes high after the fourth alignment multiframe and implies `fs_locked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 32 | Four decoded octets, octet 0 earliest |
| rx_is_k | input | 4 | Per-octet control-character flag |
| rx_bad | input | 4 | Per-octet decode or disparity error flag |
| sync_n | output | 1 | Synchronization request, low requests |
| cgs_done | output | 1 | Code group synchronization complete |
| fs_locked | output | 1 | Frame synchronization in data state |
| ilas_done | output | 1 | Alignment sequence finished |
| cfg_valid | output | 1 | Configuration registers hold a complete set |
| ila_err | output | 1 | Pulse: alignment multiframe missing its end marker |
| cfg0 | output | 32 | Configuration octets 0 to 3 |
| cfg1 | output | 32 | Configuration octets 4 to 7 |
| cfg2 | output | 32 | Configuration octets 8 to 11 |
| cfg3 | output | 32 | Configuration octets 12 and 13 |

## Verification
The bench builds the block with its defaults: a 32-octet multiframe, runs of four commas and four clean characters, and a limit of three errors. The 32-octet multiframe gives an 8-cycle error window, so tolerated errors in separate windows and a dropping burst fit in a few dozen cycles. Runs of four let the bench place a run across a word boundary, and an error in the middle of a word, so that octet-by-octet counting is exercised. The alignment sequence is started at each of the four byte offsets with random configuration octets, so every packing position and lane offset is reached.

// File: rtl/rx_link_sync.sv
module rx_link_sync #(
  parameter int MF_OCTETS = 32,
  parameter int COMMA_RUN = 4,
  parameter int CHECK_RUN = 4,
  parameter int ERR_LIMIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_is_k,
  input  logic [3:0]  rx_bad,
  output logic        sync_n,
  output logic        cgs_done,
  output logic        fs_locked,
  output logic        ilas_done,
  output logic        cfg_valid,
  output logic        ila_err,
  output logic [31:0] cfg0,
  output logic [31:0] cfg1,
  output logic [31:0] cfg2,
  output logic [31:0] cfg3
);

  localparam int POS_W    = $clog2(MF_OCTETS);
  localparam int MF_WORDS = MF_OCTETS / 4;
  localparam int WIN_W    = (MF_WORDS > 1) ? $clog2(MF_WORDS) : 1;
  localparam int CNT_W    = $clog2(COMMA_RUN + CHECK_RUN + ERR_LIMIT + 1);

  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(MF_OCTETS - 1);
  localparam logic [POS_W-1:0] CFG_FIRST = POS_W'(2);
  localparam logic [POS_W-1:0] CFG_END   = POS_W'(16);
  localparam logic [POS_W-1:0] Q_POS     = POS_W'(1);
  localparam logic [WIN_W-1:0] LAST_WORD = WIN_W'(MF_WORDS - 1);
  localparam logic [CNT_W-1:0] K_LIM     = CNT_W'(COMMA_RUN);
  localparam logic [CNT_W-1:0] V_LIM     = CNT_W'(CHECK_RUN);
  localparam logic [CNT_W-1:0] E_LIM     = CNT_W'(ERR_LIMIT);

  localparam logic [7:0] CH_COMMA = 8'hBC;
  localparam logic [7:0] CH_START = 8'h1C;
  localparam logic [7:0] CH_CONF  = 8'h9C;
  localparam logic [7:0] CH_ALIGN = 8'h7C;

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCK} cgs_t;

  cgs_t             st_q, st_d;
  logic [CNT_W-1:0] kcnt_q, kcnt_d, vcnt_q, vcnt_d, ecnt_q, ecnt_d;
  logic [WIN_W-1:0] wcnt_q, wcnt_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [1:0]       mf_q, mf_d;
  logic             fs_q, fs_d, seq_q, seq_d, done_q, done_d;
  logic             qok_q, qok_d, cval_q, cval_d, aerr_q, aerr_d;
  logic [3:0][31:0] cfg_q, cfg_d;

  always_comb begin
    logic [7:0] oct;
    logic       isk, bad;
    logic [3:0] ci;
    st_d = st_q;  kcnt_d = kcnt_q;  vcnt_d = vcnt_q;  ecnt_d = ecnt_q;
    wcnt_d = wcnt_q;  pos_d = pos_q;  mf_d = mf_q;  fs_d = fs_q;
    seq_d = seq_q;  done_d = done_q;  qok_d = qok_q;  cval_d = cval_q;
    cfg_d = cfg_q;  aerr_d = 1'b0;
    for (int i = 0; i < 4; i++) begin
      oct = rx_data[8*i +: 8];
      isk = rx_is_k[i];
      bad = rx_bad[i];
      ci  = 4'(pos_d - CFG_FIRST);
      case (st_d)
        ST_HUNT: begin
          if (isk && !bad && oct == CH_COMMA) begin
            kcnt_d = kcnt_d + 1'b1;
            if (kcnt_d == K_LIM) begin
              st_d   = ST_VERIFY;
              vcnt_d = '0;
            end
          end else begin
            kcnt_d = '0;
          end
        end
        ST_VERIFY: begin
          if (bad) begin
            st_d   = ST_HUNT;
            kcnt_d = '0;
          end else begin
            vcnt_d = vcnt_d + 1'b1;
            if (vcnt_d == V_LIM) begin
              st_d   = ST_LOCK;
              ecnt_d = '0;
              wcnt_d = '0;
            end
          end
        end
        default: begin
          if (bad) begin
            ecnt_d = ecnt_d + 1'b1;
            if (ecnt_d == E_LIM) begin
              st_d   = ST_HUNT;
              kcnt_d = '0;
              fs_d   = 1'b0;
              seq_d  = 1'b0;
              done_d = 1'b0;
              qok_d  = 1'b0;
              cval_d = 1'b0;
            end
          end
          if (st_d == ST_LOCK) begin
            if (!fs_d && !(isk && oct == CH_COMMA)) begin
              fs_d  = 1'b1;
              pos_d = '0;
              mf_d  = 2'd0;
              seq_d = isk && oct == CH_START;
              qok_d = 1'b0;
            end
            if (fs_d && seq_d) begin
              if (mf_d == 2'd1 && pos_d == Q_POS && isk && oct == CH_CONF)
                qok_d = 1'b1;
              if (mf_d == 2'd1 && pos_d >= CFG_FIRST && pos_d < CFG_END)
                cfg_d[ci[3:2]][{ci[1:0], 3'b000} +: 8] = oct;
              if (pos_d == LAST_POS) begin
                if (!(isk && oct == CH_ALIGN)) aerr_d = 1'b1;
                if (mf_d == 2'd1) cval_d = qok_d;
                if (mf_d == 2'd3) begin
                  seq_d  = 1'b0;
                  done_d = 1'b1;
                end
                mf_d = mf_d + 2'd1;
              end
            end
            if (fs_d) pos_d = (pos_d == LAST_POS) ? '0 : pos_d + 1'b1;
          end
        end
      endcase
    end
    if (st_d == ST_LOCK) begin
      if (wcnt_d == LAST_WORD) begin
        wcnt_d = '0;
        ecnt_d = '0;
      end else begin
        wcnt_d = wcnt_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      kcnt_q <= '0;  vcnt_q <= '0;  ecnt_q <= '0;  wcnt_q <= '0;
      pos_q  <= '0;  mf_q   <= '0;
      fs_q   <= 1'b0;  seq_q <= 1'b0;  done_q <= 1'b0;
      qok_q  <= 1'b0;  cval_q <= 1'b0;  aerr_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      st_q   <= st_d;
      kcnt_q <= kcnt_d;  vcnt_q <= vcnt_d;  ecnt_q <= ecnt_d;  wcnt_q <= wcnt_d;
      pos_q  <= pos_d;  mf_q   <= mf_d;
      fs_q   <= fs_d;  seq_q <= seq_d;  done_q <= done_d;
      qok_q  <= qok_d;  cval_q <= cval_d;  aerr_q <= aerr_d;
      cfg_q  <= cfg_d;
    end
  end

  assign sync_n    = (st_q != ST_HUNT);
  assign cgs_done  = (st_q == ST_LOCK);
  assign fs_locked = fs_q;
  assign ilas_done = done_q;
  assign cfg_valid = cval_q;
  assign ila_err   = aerr_q;
  assign cfg0      = cfg_q[0];
  assign cfg1      = cfg_q[1];
  assign cfg2      = cfg_q[2];
  assign cfg3      = cfg_q[3];

endmodule

// File: rtl/rx_link_sync_chk.sv
module rx_link_sync_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sync_n,
  input logic        cgs_done,
  input logic        fs_locked,
  input logic        ilas_done,
  input logic        cfg_valid,
  input logic        ila_err,
  input logic [31:0] cfg0,
  input logic [31:0] cfg1,
  input logic [31:0] cfg2,
  input logic [31:0] cfg3
);

  logic [127:0] cfg_all;
  assign cfg_all = {cfg3, cfg2, cfg1, cfg0};

  AST_DONE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cgs_done |-> sync_n); // R3
  AST_VERIFY_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cgs_done) |-> $past(sync_n)); // R3
  AST_FRAME_NEEDS_CGS: assert property (@(posedge clk) disable iff (!rst_n)
    fs_locked |-> cgs_done); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_locked |=> $stable(cfg_all)); // R6
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> fs_locked); // R6
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> (!cgs_done && !fs_locked && !cfg_valid && !ilas_done)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ila_err |=> !ila_err); // R8
  AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_done |-> fs_locked); // R9

endmodule

bind rx_link_sync rx_link_sync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .cgs_done(cgs_done),
  .fs_locked(fs_locked), .ilas_done(ilas_done), .cfg_valid(cfg_valid),
  .ila_err(ila_err), .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
);

// File: tb/sim_rx_link_sync.sv
module sim_rx_link_sync;
  localparam logic [31:0] C4 = 32'hBCBC_BCBC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_is_k = '0, rx_bad = '0;
  logic        sync_n, cgs_done, fs_locked, ilas_done, cfg_valid, ila_err;
  logic [31:0] cfg0, cfg1, cfg2, cfg3;

  always #2 clk = ~clk;

  rx_link_sync u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_is_k(rx_is_k), .rx_bad(rx_bad),
    .sync_n(sync_n), .cgs_done(cgs_done), .fs_locked(fs_locked), .ilas_done(ilas_done),
    .cfg_valid(cfg_valid), .ila_err(ila_err),
    .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
  );

  int checks = 0, fails = 0, aerr_seen = 0, fill = 0;
  logic [7:0]  cfgb [14];
  logic [31:0] wd;
  logic [3:0]  wk, we;

  always @(posedge clk) if (rst_n && ila_err) aerr_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [31:0] d, input logic [3:0] k, input logic [3:0] e);
    rx_data = d; rx_is_k = k; rx_bad = e;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] o, input logic k, input logic e);
    wd[8*fill +: 8] = o; wk[fill] = k; we[fill] = e;
    fill++;
    if (fill == 4) begin
      send(wd, wk, we);
      fill = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) send('0, '0, '0);
    rst_n = 1'b1;
    fill = 0;
  endtask

  task automatic link_up();
    send(C4, 4'hF, 4'h0);
    send(C4, 4'hF, 4'h0);
  endtask

  function automatic logic [31:0] pack(input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (4*w + b < 14) r[8*b +: 8] = cfgb[4*w + b];
    return r;
  endfunction

  task automatic run_ilas(input int off, input bit bad_end, input bit with_start);
    for (int i = 0; i < off; i++) push(8'hBC, 1'b1, 1'b0);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 32; p++) begin
        if (p == 0 && with_start)      push(8'h1C, 1'b1, 1'b0);
        else if (p == 31)              push(bad_end && m == 2 ? 8'h11 : 8'h7C, !(bad_end && m == 2), 1'b0);
        else if (m == 1 && p == 1)     push(8'h9C, 1'b1, 1'b0);
        else if (m == 1 && p < 16)     push(cfgb[p-2], 1'b0, 1'b0);
        else                           push(8'(p + 16*m), 1'b0, 1'b0);
      end
    while (fill != 0) push(8'h5A, 1'b0, 1'b0);
    send($urandom, 4'h0, 4'h0);
    send($urandom, 4'h0, 4'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(24680));
    @(negedge clk);
    do_reset();
    chk("R1 sync_n", 32'(sync_n), 0);
    chk("R1 cgs_done", 32'(cgs_done), 0);
    chk("R1 fs_locked", 32'(fs_locked), 0);
    chk("R1 cfg_valid", 32'(cfg_valid), 0);
    chk("R1 cfg0", cfg0, 0);

    send(32'h00BC_BCBC, 4'h7, 4'h0);
    chk("R2 broken run keeps request", 32'(sync_n), 0);
    send(C4, 4'hF, 4'h0);
    chk("R2 four commas release", 32'(sync_n), 1);
    chk("R3 not yet locked", 32'(cgs_done), 0);
    send(C4, 4'hF, 4'b0100);
    chk("R4 error in check", 32'(sync_n), 0);
    send(C4, 4'hF, 4'h0);
    chk("R2 run across words", 32'(sync_n), 1);
    chk("R3 one clean char only", 32'(cgs_done), 0);
    send(C4, 4'hF, 4'h0);
    chk("R3 lock after four clean", 32'(cgs_done), 1);
    send(C4, 4'hF, 4'h0);
    chk("R5 commas keep frame idle", 32'(fs_locked), 0);

    for (int off = 0; off < 4; off++) begin
      do_reset();
      link_up();
      for (int j = 0; j < 14; j++) cfgb[j] = 8'($urandom);
      for (int n = $urandom_range(0, 3); n > 0; n--) send(C4, 4'hF, 4'h0);
      aerr_seen = 0;
      run_ilas(off, off == 3, 1'b1);
      chk("R5 frame lock", 32'(fs_locked), 1);
      chk("R9 sequence done", 32'(ilas_done), 1);
      chk("R6 cfg_valid", 32'(cfg_valid), 1);
      chk("R6 cfg0", cfg0, pack(0));
      chk("R6 cfg1", cfg1, pack(1));
      chk("R6 cfg2", cfg2, pack(2));
      chk("R6 cfg3", cfg3, pack(3));
      chk("R8 end marker errors", 32'(aerr_seen), (off == 3) ? 1 : 0);
    end

    send($urandom, 4'h0, 4'b0011);
    chk("R7 two errors tolerated", 32'(cgs_done), 1);
    for (int n = 0; n < 16; n++) send($urandom, 4'h0, 4'h0);
    send($urandom, 4'h0, 4'b1100);
    chk("R7 new window count", 32'(cgs_done), 1);
    chk("R7 frame kept", 32'(fs_locked), 1);
    chk("R6 cfg held", cfg1, pack(1));
    send($urandom, 4'h0, 4'b0111);
    chk("R7 drop sync_n", 32'(sync_n), 0);
    chk("R7 drop cgs_done", 32'(cgs_done), 0);
    chk("R7 drop fs_locked", 32'(fs_locked), 0);
    chk("R7 drop cfg_valid", 32'(cfg_valid), 0);
    chk("R7 drop ilas_done", 32'(ilas_done), 0);

    do_reset();
    link_up();
    run_ilas(1, 1'b0, 1'b0);
    chk("R5 lock on plain data", 32'(fs_locked), 1);
    chk("R6 no sequence without start", 32'(ilas_done), 0);
    chk("R6 no cfg without start", 32'(cfg_valid), 0);
    chk("R6 cfg untouched", cfg0, 0);
    report();
  end
endmodule